// File: doc/BRIEF.md
# Redundant Four-Lane Packet Spreader

This block sits at the egress of one processing module and hands its outgoing packets to four parallel interprocessor data lanes. Any lane may carry any packet. For each new packet the block draws a pseudo-random number and maps it onto the set of lanes that are currently marked healthy, so that traffic spreads evenly across them. Once a lane has been picked, every beat of that packet goes to it, until the end-of-packet beat is accepted.

Each lane reports its health on its own input. A lane that drops out receives no further new packets, and the load moves to the lanes that are left. A packet already in flight stays on its lane, even if that lane fails part way through. When no lane is healthy, the block stops accepting input and raises a status flag. It resumes once any lane returns. Each lane has a 32-bit counter of the packets that completed on it.

The control is a three-state machine. In `ST_IDLE` the block waits for the first beat of a packet. In `ST_BUSY` a packet is in flight on a locked lane. In `ST_DOWN` no lane is usable. The transitions are:

- IDLE→BUSY: the first beat is accepted and it is not an end beat.
- BUSY→IDLE: the end beat is accepted.
- IDLE→DOWN: no lane is healthy.
- DOWN→IDLE: any lane is healthy again.
- IDLE→IDLE: a single-beat packet is accepted.

Top module: `lane_spreader`

## Requirements
- R1: After reset, no lane output is valid, every packet counter reads zero and `all_down` is low while at least one lane is up.
- R2: At most one bit of `lane_valid` is high in any cycle.
- R3: The first beat of a packet is offered only to a lane whose `lane_up` bit is 1 in that cycle.
- R4: Every later beat of a packet goes to the same lane as its first beat, until the beat with `in_eop`=1 is accepted. This holds even if that lane's `lane_up` falls mid-packet.
- R5: A lane whose `lane_up` is 0 receives no new packets; new packets go only to the lanes that remain up.
- R6: With all four lanes up, each lane receives at least 15% of a long run of packets. With one lane down, each of the three remaining lanes receives at least 15%.
- R7: When all `lane_up` bits are 0 and no packet is in flight, `in_ready` is 0 and no lane is valid. `all_down` reads 1 from the next clock. Traffic resumes one clock after any lane returns.
- R8: The selected lane carries `in_data`, `in_sop` and `in_eop` unchanged, its valid equals `in_valid`, and `in_ready` equals that lane's ready. `in_ready` is 0 while no lane is valid.
- R9: Lane i's counter (bits `[32*i +: 32]` of `pkt_count`) increments by one on each accepted beat with `in_eop`=1 on lane i, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_data | input | 32 | Input beat payload |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| lane_up | input | 4 | Per-lane health, 1 = usable |
| lane_valid | output | 4 | Per-lane beat valid |
| lane_ready | input | 4 | Per-lane ready |
| lane_data | output | 128 | Lane i payload at bits [32*i +: 32] |
| lane_sop | output | 4 | Per-lane first-beat marker |
| lane_eop | output | 4 | Per-lane last-beat marker |
| pkt_count | output | 128 | Lane i completed-packet count at bits [32*i +: 32] |
| all_down | output | 1 | High while no lane is usable |

## Verification
Several rules are checked by assertions on every cycle:

- that no more than one lane is valid;
- that a packet's first beat lands on a healthy lane;
- that a packet keeps its lane after a non-final beat;
- that input is refused when nothing is up;
- that a counter moves only on an accepted end beat.

Other behaviours only show up in the bench's scenarios: how evenly packets spread over the lanes, that a failed lane is fully excluded over many packets, the mid-packet failure case, and recovery from the all-down state. The bench drives random packet lengths and random lane backpressure, and compares the counters with its own tallies.

// File: rtl/lane_spreader_pkg.sv
package lane_spreader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DOWN = 2'd2
    } ls_state_e;

endpackage

// File: rtl/ls_prng.sv
module ls_prng #(
    parameter int          W    = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED[W-1:0];
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS[W-1:0];
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign rnd = state_q;

    p_never_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0)
        else $error("prng reached zero");
endmodule

// File: rtl/ls_pick.sv
module ls_pick #(
    parameter int LANES  = 4,
    parameter int RND_W  = 16,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [RND_W-1:0] rnd,
    input  logic [LANES-1:0] up,
    output logic [IDX_W-1:0] idx,
    output logic             any_up
);
    logic [7:0] n_up;
    logic [7:0] sel;
    logic [7:0] k;

    always_comb begin
        n_up   = 8'($countones(up));
        any_up = (n_up != 8'd0);
        sel    = any_up ? (rnd[7:0] % n_up) : 8'd0;
        idx    = '0;
        k      = 8'd0;
        for (int i = 0; i < LANES; i++) begin
            if (up[i]) begin
                if (k == sel) begin
                    idx = IDX_W'(i);
                end
                k = k + 8'd1;
            end
        end
    end
endmodule

// File: rtl/ls_counter.sv
module ls_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    p_count_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> $past(inc))
        else $error("counter changed without an end beat");
endmodule

// File: rtl/lane_spreader.sv
module lane_spreader
    import lane_spreader_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          LANES  = 4,
    parameter int          CNT_W  = 32,
    parameter logic [15:0] SEED   = 16'hACE1,
    localparam int         IDX_W  = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DATA_W-1:0]       in_data,
    input  logic                    in_sop,
    input  logic                    in_eop,
    input  logic [LANES-1:0]        lane_up,
    output logic [LANES-1:0]        lane_valid,
    input  logic [LANES-1:0]        lane_ready,
    output logic [LANES*DATA_W-1:0] lane_data,
    output logic [LANES-1:0]        lane_sop,
    output logic [LANES-1:0]        lane_eop,
    output logic [LANES*CNT_W-1:0]  pkt_count,
    output logic                    all_down
);
    ls_state_e        state_q, state_d;
    logic [IDX_W-1:0] lock_q;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] tgt;
    logic             pick_ok;
    logic             route_en;
    logic             accept;
    logic [15:0]      rnd;

    ls_prng #(.W(16), .SEED(SEED)) u_prng (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    ls_pick #(.LANES(LANES), .RND_W(16)) u_pick (
        .rnd    (rnd),
        .up     (lane_up),
        .idx    (pick_idx),
        .any_up (pick_ok)
    );

    // Output process: steer the beat to the chosen lane
    always_comb begin
        tgt        = (state_q == ST_BUSY) ? lock_q : pick_idx;
        route_en   = (state_q == ST_BUSY) || ((state_q == ST_IDLE) && pick_ok);
        lane_valid = '0;
        if (route_en) begin
            lane_valid[tgt] = in_valid;
        end
        in_ready = route_en && lane_ready[tgt];
        accept   = in_valid && in_ready;
        all_down = (state_q == ST_DOWN);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_data[g*DATA_W +: DATA_W] = in_data;
        assign lane_sop[g] = in_sop;
        assign lane_eop[g] = in_eop;

        ls_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (lane_valid[g] && lane_ready[g] && in_eop),
            .count (pkt_count[g*CNT_W +: CNT_W])
        );
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!pick_ok) begin
                    state_d = ST_DOWN;
                end else if (accept && !in_eop) begin
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (accept && in_eop) begin
                    state_d = ST_IDLE;
                end
            end
            ST_DOWN: begin
                if (pick_ok) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && accept) begin
                lock_q <= pick_idx;
            end
        end
    end

    p_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_valid))
        else $error("more than one lane valid");

    p_start_healthy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && accept) |-> ((lane_valid & lane_up) != '0))
        else $error("packet started on a dead lane");

    p_keep_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_eop) |=> (!in_valid || lane_valid == $past(lane_valid)))
        else $error("packet changed lane");

    p_refuse_when_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_up == '0 && state_q != ST_BUSY) |-> !in_ready)
        else $error("input accepted with no lane up");

    p_ready_needs_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_valid == '0) |-> !in_ready)
        else $error("ready without a target lane");
endmodule

// File: tb/lane_spreader_test.sv
`timescale 1ns/100ps
module lane_spreader_test;
    localparam int DW = 32;
    localparam int NL = 4;
    localparam int CW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [DW-1:0]   in_data = '0;
    logic            in_sop = 1'b0;
    logic            in_eop = 1'b0;
    logic [NL-1:0]   lane_up = '1;
    logic [NL-1:0]   lane_valid;
    logic [NL-1:0]   lane_ready = '1;
    logic [NL*DW-1:0] lane_data;
    logic [NL-1:0]   lane_sop;
    logic [NL-1:0]   lane_eop;
    logic [NL*CW-1:0] pkt_count;
    logic            all_down;

    int checks = 0;
    int errors = 0;
    int exp_cnt [NL];
    int kill_mid = 0;

    always #2.5 clk = ~clk;

    lane_spreader uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .lane_up(lane_up),
        .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_data(lane_data),
        .lane_sop(lane_sop), .lane_eop(lane_eop), .pkt_count(pkt_count),
        .all_down(all_down)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lane_of(input logic [NL-1:0] v);
        for (int i = 0; i < NL; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int min_share(input int total, input int pct);
        return (total * pct) / 100;
    endfunction

    task automatic check_counts(input string tag);
        for (int i = 0; i < NL; i++)
            check(pkt_count[i*CW +: CW] == CW'(exp_cnt[i]), tag,
                  pkt_count[i*CW +: CW], exp_cnt[i]);
    endtask

    // Sends one packet; returns the lane it went to
    task automatic send_pkt(input int len, output int lane);
        int pend_kill;
        lane = -1;
        pend_kill = 0;
        for (int b = 0; b < len; b++) begin
            bit done;
            logic [DW-1:0] d;
            done = 0;
            d = $urandom;
            while (!done) begin
                @(negedge clk);
                if (pend_kill) begin
                    lane_up[lane] = 1'b0;
                    pend_kill = 0;
                end
                in_valid = 1'b1;
                in_data  = d;
                in_sop   = (b == 0);
                in_eop   = (b == len - 1);
                for (int i = 0; i < NL; i++) lane_ready[i] = ($urandom % 4) != 0;
                #1;
                check($onehot(lane_valid), "R2 one lane valid", lane_valid, 1);
                if (b == 0) begin
                    lane = lane_of(lane_valid);
                    if (lane >= 0)
                        check(lane_up[lane] == 1'b1, "R3/R5 start on live lane", lane, -1);
                end else if (lane >= 0) begin
                    check(lane_valid == NL'(1 << lane), "R4 same lane", lane_valid, 1 << lane);
                end
                if (lane >= 0) begin
                    check(lane_data[lane*DW +: DW] == d, "R8 data", lane_data[lane*DW +: DW], d);
                    check(lane_sop[lane] == in_sop && lane_eop[lane] == in_eop, "R8 markers",
                          {lane_sop[lane], lane_eop[lane]}, {in_sop, in_eop});
                    check(in_ready == lane_ready[lane], "R8 ready", in_ready, lane_ready[lane]);
                    if (in_ready) begin
                        done = 1;
                        if (b == len - 1) exp_cnt[lane]++;
                        if (b == 0 && kill_mid != 0 && len > 1) begin
                            pend_kill = 1;
                            kill_mid  = 0;
                        end
                    end
                end else begin
                    done = 1;
                end
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ln;
        int base [NL];
        int tot;
        void'($urandom(32'd1234));
        for (int i = 0; i < NL; i++) exp_cnt[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(lane_valid == '0, "R1 no lane valid", lane_valid, 0);
        check(all_down == 1'b0, "R1 all_down low", all_down, 0);
        check_counts("R1 counters zero");

        // R6 spread over four lanes, random lengths
        tot = 400;
        for (int p = 0; p < tot; p++) send_pkt(1 + ($urandom % 4), ln);
        for (int i = 0; i < NL; i++)
            check(exp_cnt[i] >= min_share(tot, 15), "R6 four-lane share", exp_cnt[i], min_share(tot, 15));
        check_counts("R9 counts after spread");

        // R4 lane fails mid-packet: packet stays, lane excluded afterwards
        kill_mid = 1;
        send_pkt(5, ln);
        check(lane_up[ln] == 1'b0, "R4 victim lane dropped", lane_up[ln], 0);
        for (int i = 0; i < NL; i++) base[i] = exp_cnt[i];
        check_counts("R4 packet finished on failed lane");

        // R5 failover over the remaining three lanes
        tot = 240;
        for (int p = 0; p < tot; p++) send_pkt(1 + ($urandom % 3), ln);
        check(exp_cnt[ln_dead(lane_up)] == base[ln_dead(lane_up)], "R5 dead lane idle",
              exp_cnt[ln_dead(lane_up)], base[ln_dead(lane_up)]);
        for (int i = 0; i < NL; i++)
            if (lane_up[i])
                check(exp_cnt[i] - base[i] >= min_share(tot, 15), "R6 three-lane share",
                      exp_cnt[i] - base[i], min_share(tot, 15));
        check_counts("R9 counts after failover");

        // R7 all lanes down
        @(negedge clk);
        lane_up  = '0;
        in_valid = 1'b1;
        in_sop   = 1'b1;
        in_eop   = 1'b1;
        #1;
        check(in_ready == 1'b0, "R7 ready low", in_ready, 0);
        check(lane_valid == '0, "R7 no lane valid", lane_valid, 0);
        @(negedge clk);
        #1;
        check(all_down == 1'b1, "R7 all_down high", all_down, 1);
        check(in_ready == 1'b0, "R7 ready still low", in_ready, 0);
        @(negedge clk);
        lane_up  = 4'b0100;
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        check(all_down == 1'b0, "R7 recovered", all_down, 0);
        for (int i = 0; i < NL; i++) base[i] = exp_cnt[i];
        for (int p = 0; p < 20; p++) begin
            send_pkt(1 + ($urandom % 3), ln);
            check(ln == 2, "R5 only live lane used", ln, 2);
        end
        check(exp_cnt[2] - base[2] == 20, "R9 single-lane count", exp_cnt[2] - base[2], 20);
        @(negedge clk);
        check_counts("R9 final counts");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int ln_dead(input logic [NL-1:0] up);
        for (int i = 0; i < NL; i++) if (!up[i]) return i;
        return 0;
    endfunction
endmodule